// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block sits beside a two-port RAM and turns ordinary accesses to two reserved words into interrupts between the two sides. The topmost address is the right side's mailbox. The address just below it is the left side's mailbox. When one side writes into the other side's mailbox, the owner's active-low interrupt asserts. The owner removes its interrupt by reading its own mailbox. A side that reads the other side's mailbox leaves that interrupt untouched.

Each side receives an arbitration hold from the contention arbiter. While a side's hold is active, its mailbox write cannot raise the other side's interrupt, and its read of its own mailbox cannot clear its own interrupt. The block also returns, for each side, a qualifier that shows whether that side's write may reach the RAM array. The storage itself and the arbiter are outside this block.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: After a synchronous reset, `lf_irq_n` and `rt_irq_n` are both 1.
- R2: A left write (`lf_sel_n`=0, `lf_wr_n`=0) to address 0x1FFF with `lf_hold_n`=1 drives `rt_irq_n` to 0 at the next clock edge.
- R3: A right write to address 0x1FFE with `rt_hold_n`=1 drives `lf_irq_n` to 0 at the next clock edge.
- R4: An owner read of its own mailbox (left reads 0x1FFE, right reads 0x1FFF) with its hold inactive drives the owner's interrupt to 1 at the next clock edge.
- R5: A read by one side of the other side's mailbox leaves that interrupt unchanged.
- R6: While a side's hold input is 0, its write to the other side's mailbox leaves the other interrupt unchanged.
- R7: While a side's hold input is 0, its read of its own mailbox leaves its interrupt unchanged.
- R8: A read counts only when `*_sel_n`=0, `*_wr_n`=1 and `*_rden_n`=0 together. With `*_rden_n`=1, an owner access to its own mailbox clears nothing.
- R9: When the same interrupt receives a set and a clear in the same cycle, the set wins and the interrupt is 0 after the edge.
- R10: `*_wr_ok` is 1 exactly when that side has `*_sel_n`=0, `*_wr_n`=0 and `*_hold_n`=1. It is combinational.
- R11: A write to any address other than the other side's mailbox changes no interrupt. This includes a write to the writer's own mailbox.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lf_sel_n | input | 1 | Left chip select, active low |
| lf_wr_n | input | 1 | Left write strobe, active low (1 = read) |
| lf_rden_n | input | 1 | Left output enable, active low |
| lf_addr | input | 13 | Left word address |
| lf_hold_n | input | 1 | Left arbitration hold from arbiter, active low |
| rt_sel_n | input | 1 | Right chip select, active low |
| rt_wr_n | input | 1 | Right write strobe, active low (1 = read) |
| rt_rden_n | input | 1 | Right output enable, active low |
| rt_addr | input | 13 | Right word address |
| rt_hold_n | input | 1 | Right arbitration hold from arbiter, active low |
| lf_irq_n | output | 1 | Left interrupt, active low, registered |
| rt_irq_n | output | 1 | Right interrupt, active low, registered |
| lf_wr_ok | output | 1 | Left write may reach the array |
| rt_wr_ok | output | 1 | Right write may reach the array |

## Verification
The checker tests several rules on every cycle. An unblocked write into the other side's mailbox always produces a low interrupt one edge later. An unblocked owner read with no competing set always releases the interrupt. An interrupt changes only after an unblocked set or clear. The write qualifier never asserts while its hold is active. Some properties depend on sequence, and only the bench scenarios show them: a foreign read that leaves a pending flag alone, the need for the output enable, and the set-beats-clear collision. Both mailboxes are written in one cycle, then both owners read in one cycle. A reset that arrives while a flag is pending must also clear it.

// File: rtl/mbox_pkg.sv
// Package mbox_pkg
// Shared types for the mailbox interrupt controller.
// Assumes: address width is chosen by the top-level parameter.
package mbox_pkg;

    // Decoded effect of one side's access in the current cycle
    typedef struct packed {
        logic set_peer;   // unblocked write into the other side's mailbox
        logic clr_own;    // unblocked read of this side's own mailbox
        logic wr_ok;      // write may proceed to the array
    } side_evt_t;

endpackage

// File: rtl/mbox_side_dec.sv
// Module mbox_side_dec
// Decodes one side's control strobes and address into mailbox events.
// Assumes: all strobes are active low and sampled synchronously.
// OWN_ADDR is this side's mailbox and PEER_ADDR is the other side's.
module mbox_side_dec
    import mbox_pkg::*;
#(
    parameter int          AW        = 13,
    parameter logic [AW-1:0] OWN_ADDR  = '1,
    parameter logic [AW-1:0] PEER_ADDR = '1
) (
    input  logic          sel_n,
    input  logic          wr_n,
    input  logic          rden_n,
    input  logic [AW-1:0] addr,
    input  logic          hold_n,
    output side_evt_t     evt
);

    logic wr_req;
    logic rd_req;
    logic free;

    // Classify the access and gate it with the arbiter hold
    always_comb begin
        wr_req       = !sel_n && !wr_n;
        rd_req       = !sel_n && wr_n && !rden_n;
        free         = hold_n;
        evt.set_peer = wr_req && free && (addr == PEER_ADDR);
        evt.clr_own  = rd_req && free && (addr == OWN_ADDR);
        evt.wr_ok    = wr_req && free;
    end

endmodule

// File: rtl/mbox_flag.sv
// Module mbox_flag
// One pending-interrupt flag. A set takes priority over a clear in the
// same cycle, so no message is lost.
// Assumes: synchronous active-low reset.
module mbox_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n
);

    logic pend_q;

    // Hold, raise or drop the pending flag; raising wins over dropping
    always_ff @(posedge clk) begin
        if (!rst_n)     pend_q <= 1'b0;
        else if (set_i) pend_q <= 1'b1;
        else if (clr_i) pend_q <= 1'b0;
    end

    // Present the flag as an active-low interrupt
    always_comb irq_n = !pend_q;

endmodule

// File: rtl/mbox_irq_ctrl.sv
// Module mbox_irq_ctrl
// Mailbox interrupt controller for a two-port RAM. The top word belongs
// to the right side and the word below it belongs to the left side.
// Writes into the other side's mailbox raise the owner's interrupt, and
// owner reads clear it. An active arbitration hold blocks both.
// Assumes: the hold inputs come from an external contention arbiter.
module mbox_irq_ctrl
    import mbox_pkg::*;
#(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lf_sel_n,
    input  logic          lf_wr_n,
    input  logic          lf_rden_n,
    input  logic [AW-1:0] lf_addr,
    input  logic          lf_hold_n,
    input  logic          rt_sel_n,
    input  logic          rt_wr_n,
    input  logic          rt_rden_n,
    input  logic [AW-1:0] rt_addr,
    input  logic          rt_hold_n,
    output logic          lf_irq_n,
    output logic          rt_irq_n,
    output logic          lf_wr_ok,
    output logic          rt_wr_ok
);

    localparam logic [AW-1:0] RT_BOX = {AW{1'b1}};
    localparam logic [AW-1:0] LF_BOX = RT_BOX - 1'b1;
    localparam int NSIDE = 2;

    side_evt_t       evt   [NSIDE];
    logic            sel_v [NSIDE];
    logic            wr_v  [NSIDE];
    logic            rd_v  [NSIDE];
    logic [AW-1:0]   adr_v [NSIDE];
    logic            hld_v [NSIDE];
    logic            irq_v [NSIDE];

    // Gather both sides' pins into indexed form (0 = left, 1 = right)
    always_comb begin
        sel_v[0] = lf_sel_n;  sel_v[1] = rt_sel_n;
        wr_v[0]  = lf_wr_n;   wr_v[1]  = rt_wr_n;
        rd_v[0]  = lf_rden_n; rd_v[1]  = rt_rden_n;
        adr_v[0] = lf_addr;   adr_v[1] = rt_addr;
        hld_v[0] = lf_hold_n; hld_v[1] = rt_hold_n;
    end

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        localparam logic [AW-1:0] OWN  = (s == 0) ? LF_BOX : RT_BOX;
        localparam logic [AW-1:0] PEER = (s == 0) ? RT_BOX : LF_BOX;

        mbox_side_dec #(
            .AW        (AW),
            .OWN_ADDR  (OWN),
            .PEER_ADDR (PEER)
        ) dec_i (
            .sel_n  (sel_v[s]),
            .wr_n   (wr_v[s]),
            .rden_n (rd_v[s]),
            .addr   (adr_v[s]),
            .hold_n (hld_v[s]),
            .evt    (evt[s])
        );

        // Side s's flag is set by the other side and cleared by side s
        mbox_flag flag_i (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (evt[NSIDE-1-s].set_peer),
            .clr_i (evt[s].clr_own),
            .irq_n (irq_v[s])
        );
    end

    // Drive the output pins from the per-side results
    always_comb begin
        lf_irq_n = irq_v[0];
        rt_irq_n = irq_v[1];
        lf_wr_ok = evt[0].wr_ok;
        rt_wr_ok = evt[1].wr_ok;
    end

endmodule

// File: rtl/mbox_irq_chk.sv
// Module mbox_irq_chk
// Cycle-by-cycle properties for mbox_irq_ctrl, attached through bind.
// Assumes: the same address width as the controller.
module mbox_irq_chk #(
    parameter int AW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lf_sel_n,
    input logic          lf_wr_n,
    input logic          lf_rden_n,
    input logic [AW-1:0] lf_addr,
    input logic          lf_hold_n,
    input logic          rt_sel_n,
    input logic          rt_wr_n,
    input logic          rt_rden_n,
    input logic [AW-1:0] rt_addr,
    input logic          rt_hold_n,
    input logic          lf_irq_n,
    input logic          rt_irq_n,
    input logic          lf_wr_ok,
    input logic          rt_wr_ok
);

    localparam logic [AW-1:0] TOPW = {AW{1'b1}};
    localparam logic [AW-1:0] BOTW = TOPW - 1'b1;

    logic l_set, r_set, l_clr, r_clr;

    // Independent view of the set and clear conditions from the pins
    always_comb begin
        r_set = !lf_sel_n && !lf_wr_n && lf_hold_n && lf_addr == TOPW;
        l_set = !rt_sel_n && !rt_wr_n && rt_hold_n && rt_addr == BOTW;
        l_clr = !lf_sel_n && lf_wr_n && !lf_rden_n && lf_hold_n && lf_addr == BOTW;
        r_clr = !rt_sel_n && rt_wr_n && !rt_rden_n && rt_hold_n && rt_addr == TOPW;
    end

    // R2, R9: an unblocked left write into the right mailbox always raises it
    a_r2_right_set: assert property (@(posedge clk) disable iff (!rst_n)
        r_set |=> !rt_irq_n);
    // R3, R9: an unblocked right write into the left mailbox always raises it
    a_r3_left_set: assert property (@(posedge clk) disable iff (!rst_n)
        l_set |=> !lf_irq_n);
    // R4: owner read with no competing set releases the interrupt
    a_r4_left_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (l_clr && !l_set) |=> lf_irq_n);
    a_r4_right_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (r_clr && !r_set) |=> rt_irq_n);
    // R6, R11: with no unblocked set, an idle interrupt stays idle
    a_r6_left_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (lf_irq_n && !l_set) |=> lf_irq_n);
    a_r6_right_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (rt_irq_n && !r_set) |=> rt_irq_n);
    // R5, R7, R8: with no unblocked owner read, a pending interrupt stays
    a_r7_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!lf_irq_n && !l_clr) |=> !lf_irq_n);
    a_r7_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rt_irq_n && !r_clr) |=> !rt_irq_n);
    // R10: the write qualifier never passes a held or deselected write
    a_r10_left_qual: assert property (@(posedge clk) disable iff (!rst_n)
        lf_wr_ok |-> (lf_hold_n && !lf_sel_n && !lf_wr_n));
    a_r10_right_qual: assert property (@(posedge clk) disable iff (!rst_n)
        rt_wr_ok |-> (rt_hold_n && !rt_sel_n && !rt_wr_n));

endmodule

bind mbox_irq_ctrl mbox_irq_chk #(.AW(AW)) chk_i (.*);

// File: tb/mbox_irq_ctrl_tb_top.sv
// Module mbox_irq_ctrl_tb_top
// Self-checking bench: a vector table walked by one loop, then directed
// reset tests. Inputs change on the falling edge. wr_ok is sampled
// shortly after, and the interrupts are sampled after the next rising edge.
module mbox_irq_ctrl_tb_top;

    localparam int AW = 13;
    localparam logic [AW-1:0] TOPW = 13'h1FFF;
    localparam logic [AW-1:0] BOTW = 13'h1FFE;
    localparam logic [AW-1:0] OTHR = 13'h0100;

    typedef struct packed {
        logic          sel_n;
        logic          wr_n;
        logic          rden_n;
        logic [AW-1:0] addr;
        logic          hold_n;
    } side_t;

    typedef struct packed {
        logic [7:0] req;
        side_t      lf;
        side_t      rt;
        logic       e_lwok;
        logic       e_rwok;
        logic       e_lirq;
        logic       e_rirq;
    } vec_t;

    localparam side_t IDL = '{1'b1, 1'b1, 1'b1, 13'h0, 1'b1};
    localparam int NV = 14;

    localparam vec_t VECS [NV] = '{
        '{8'd1,  IDL, IDL, 1'b0, 1'b0, 1'b1, 1'b1},                                         // R1 idle
        '{8'd2,  '{1'b0,1'b0,1'b1,TOPW,1'b1}, IDL, 1'b1, 1'b0, 1'b1, 1'b0},                // R2, R10
        '{8'd5,  '{1'b0,1'b1,1'b0,TOPW,1'b1}, IDL, 1'b0, 1'b0, 1'b1, 1'b0},                // R5 foreign read
        '{8'd8,  IDL, '{1'b0,1'b1,1'b1,TOPW,1'b1}, 1'b0, 1'b0, 1'b1, 1'b0},                // R8 no output enable
        '{8'd7,  IDL, '{1'b0,1'b1,1'b0,TOPW,1'b0}, 1'b0, 1'b0, 1'b1, 1'b0},                // R7 held read
        '{8'd4,  IDL, '{1'b0,1'b1,1'b0,TOPW,1'b1}, 1'b0, 1'b0, 1'b1, 1'b1},                // R4 right clear
        '{8'd6,  '{1'b0,1'b0,1'b1,TOPW,1'b0}, IDL, 1'b0, 1'b0, 1'b1, 1'b1},                // R6, R10 held write
        '{8'd3,  IDL, '{1'b0,1'b0,1'b1,BOTW,1'b1}, 1'b0, 1'b1, 1'b0, 1'b1},                // R3
        '{8'd11, IDL, '{1'b0,1'b0,1'b1,OTHR,1'b1}, 1'b0, 1'b1, 1'b0, 1'b1},                // R11 other addr
        '{8'd11, '{1'b0,1'b0,1'b1,BOTW,1'b1}, IDL, 1'b1, 1'b0, 1'b0, 1'b1},                // R11 own-box write
        '{8'd9,  '{1'b0,1'b1,1'b0,BOTW,1'b1}, '{1'b0,1'b0,1'b1,BOTW,1'b1}, 1'b0, 1'b1, 1'b0, 1'b1}, // R9
        '{8'd4,  '{1'b0,1'b1,1'b0,BOTW,1'b1}, IDL, 1'b0, 1'b0, 1'b1, 1'b1},                // R4 left clear
        '{8'd2,  '{1'b0,1'b0,1'b1,TOPW,1'b1}, '{1'b0,1'b0,1'b1,BOTW,1'b1}, 1'b1, 1'b1, 1'b0, 1'b0}, // R2 R3 both
        '{8'd4,  '{1'b0,1'b1,1'b0,BOTW,1'b1}, '{1'b0,1'b1,1'b0,TOPW,1'b1}, 1'b0, 1'b0, 1'b1, 1'b1}  // R4 both
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    side_t lf_in = IDL;
    side_t rt_in = IDL;
    logic lf_irq_n, rt_irq_n, lf_wr_ok, rt_wr_ok;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = !clk;

    mbox_irq_ctrl #(.AW(AW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .lf_sel_n  (lf_in.sel_n),
        .lf_wr_n   (lf_in.wr_n),
        .lf_rden_n (lf_in.rden_n),
        .lf_addr   (lf_in.addr),
        .lf_hold_n (lf_in.hold_n),
        .rt_sel_n  (rt_in.sel_n),
        .rt_wr_n   (rt_in.wr_n),
        .rt_rden_n (rt_in.rden_n),
        .rt_addr   (rt_in.addr),
        .rt_hold_n (rt_in.hold_n),
        .lf_irq_n  (lf_irq_n),
        .rt_irq_n  (rt_irq_n),
        .lf_wr_ok  (lf_wr_ok),
        .rt_wr_ok  (rt_wr_ok)
    );

    task automatic check(input string what, input int req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Apply one cycle of stimulus and check both sampling points
    task automatic run_vec(input vec_t v);
        @(negedge clk);
        lf_in = v.lf;
        rt_in = v.rt;
        #1;
        check("lf_wr_ok", int'(v.req), lf_wr_ok, v.e_lwok);
        check("rt_wr_ok", int'(v.req), rt_wr_ok, v.e_rwok);
        @(posedge clk);
        #1;
        check("lf_irq_n", int'(v.req), lf_irq_n, v.e_lirq);
        check("rt_irq_n", int'(v.req), rt_irq_n, v.e_rirq);
    endtask

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("lf_irq_n after reset", 1, lf_irq_n, 1'b1);   // R1
        check("rt_irq_n after reset", 1, rt_irq_n, 1'b1);   // R1

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R1: reset drops a pending interrupt
        run_vec('{8'd2, '{1'b0,1'b0,1'b1,TOPW,1'b1}, IDL, 1'b1, 1'b0, 1'b1, 1'b0});
        @(negedge clk);
        lf_in = IDL;
        rt_in = IDL;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("rt_irq_n cleared by reset", 1, rt_irq_n, 1'b1);   // R1
        check("lf_irq_n cleared by reset", 1, lf_irq_n, 1'b1);   // R1
        @(negedge clk);
        rst_n = 1'b1;

        // R6: a held right write to the left mailbox leaves it idle
        run_vec('{8'd6, IDL, '{1'b0,1'b0,1'b1,BOTW,1'b0}, 1'b0, 1'b0, 1'b1, 1'b1});
        done = 1'b1;
    end

    initial begin : watchdog
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule